// File: doc/BRIEF.md
# Special-Function Output Pin Multiplexer

This block drives five general-purpose output pins. Each pin normally shows the bit held for it in a data register. Each pin can also be switched over to an internal waveform that is produced elsewhere: an LCD line clock, an LCD frame signal, a programmable timer clock, or a buzzer tone. Two of the pins can instead carry the complement of the timer clock or of the buzzer tone.

Each waveform has its own enable bit. When an enable bit is clear, the pin it controls is held at a fixed level. The line clock, frame and timer pins are held HIGH. The buzzer pin is held LOW. The data register bit of a pin still takes part in the result, so a wrong data setting keeps the waveform off the pin. Two static option inputs decide whether the shared pin and the inverted-buzzer pin may take an alternate function at all.

Software reaches both registers over a byte-wide bus. Writes are synchronous. Reads are combinational and return the stored bits, not the pin levels.

Top module: `sfo_outmux`

## Requirements
- R1: After reset the enable register reads 0x00 and the data register reads 0x17 (bit 3 is 0, every other implemented bit is 1). With both options asserted, the pins settle as follows: pin_lc=1, pin_shared=0, pin_tmr=1, pin_buz=0, pin_buz_n=1.
- R2: The enable register is at bus address 0. Its bits are: bit0 line clock, bit1 frame, bit2 timer, bit3 buzzer. The data register is at address 1. Its bits are: bit0 pin_lc, bit1 pin_shared, bit2 pin_tmr, bit3 pin_buz, bit4 pin_buz_n. A write takes effect on the clock edge where bus_sel and bus_wr are both high. A read with bus_sel high and bus_wr low returns the stored bits, and unimplemented bits read 0.
- R3: pin_lc equals data bit0 AND (line-clock enable ? lcd_line_clk : 1).
- R4: pin_tmr equals data bit2 AND (timer enable ? tmr_clk : 1).
- R5: When opt_b_alt is 1 and the frame enable is 0, pin_shared is the inverse of tmr_clk while the timer enable is 1, and is 0 while the timer enable is 0. In this mode data bit1 has no effect.
- R6: When opt_b_alt is 1 and the frame enable is 1, pin_shared equals data bit1 AND lcd_frame. This holds whatever the timer enable is.
- R7: When opt_b_alt is 0, pin_shared equals data bit1, whatever the enables are.
- R8: pin_buz equals data bit3 OR (buzzer enable ? buzz_in : 0).
- R9: When opt_e_inv is 1, pin_buz_n is the inverse of buzz_in while the buzzer enable is 1, and is 1 otherwise. In this mode data bit4 has no effect.
- R10: When opt_e_inv is 0, pin_buz_n equals data bit4.
- R11: The following change neither register: a write to addresses 2 or 3, and any bus cycle with bus_sel low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus cycle select |
| bus_wr | input | 1 | Write strobe (1 = write, 0 = read) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (0 when not reading) |
| lcd_line_clk | input | 1 | LCD line clock from its generator |
| lcd_frame | input | 1 | LCD frame signal from its generator |
| tmr_clk | input | 1 | Programmable timer clock |
| buzz_in | input | 1 | Buzzer tone |
| opt_b_alt | input | 1 | Static option: shared pin may take frame / inverted-timer functions |
| opt_e_inv | input | 1 | Static option: inverted-buzzer pin function allowed |
| pin_lc | output | 1 | Line clock pin |
| pin_shared | output | 1 | Frame / inverted timer pin |
| pin_tmr | output | 1 | Timer clock pin |
| pin_buz | output | 1 | Buzzer pin (LOW idle) |
| pin_buz_n | output | 1 | Inverted buzzer pin |

## Verification
The hardest state to reach is the shared pin in its mixed state. Here the option is on and both the frame and the timer enables are set, so the frame function has to win. The bench also has to show that the data bit is ignored once the frame enable is dropped and the pin falls back to the inverted timer. The stimulus reaches this by writing both enables together, toggling the frame and timer inputs on their own, and then rewriting the data bit. After each step the pin is sampled. The buzzer path gets the same treatment with data bit3 set high, which shows that the OR gate masks the tone.

// File: rtl/sfo_pkg.sv
package sfo_pkg;
  localparam int NUM_EN  = 4;
  localparam int NUM_PIN = 5;

  // enable register bit positions
  localparam int EN_LINE  = 0;
  localparam int EN_FRAME = 1;
  localparam int EN_TMR   = 2;
  localparam int EN_BUZ   = 3;

  // data register bit positions
  localparam int D_LC     = 0;
  localparam int D_SHARED = 1;
  localparam int D_TMR    = 2;
  localparam int D_BUZ    = 3;
  localparam int D_BUZN   = 4;

  typedef logic [NUM_EN-1:0]  en_vec_t;
  typedef logic [NUM_PIN-1:0] pin_vec_t;

  // HIGH-idle gating: data masks the waveform, idle is 1
  function automatic logic gate_high(input logic dat, input logic en, input logic sig);
    return dat & (en ? sig : 1'b1);
  endfunction

  // LOW-idle gating: data overrides the waveform, idle is 0
  function automatic logic gate_low(input logic dat, input logic en, input logic sig);
    return dat | (en ? sig : 1'b0);
  endfunction
endpackage

// File: rtl/sfo_regs.sv
module sfo_regs
  import sfo_pkg::*;
#(
  parameter int       ADDR_W    = 2,
  parameter int       DATA_W    = 8,
  parameter int       CTRL_ADDR = 0,
  parameter int       DATA_ADDR = 1,
  parameter pin_vec_t DATA_RST  = 5'b10111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output en_vec_t           ctrl_q,
  output pin_vec_t          data_q,
  output logic              wr_ctrl,
  output logic              wr_data
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);

  assign wr_ctrl = bus_sel && bus_wr && (bus_addr == A_CTRL);
  assign wr_data = bus_sel && bus_wr && (bus_addr == A_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      data_q <= DATA_RST;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata[NUM_EN-1:0];
      if (wr_data) data_q <= bus_wdata[NUM_PIN-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (bus_addr == A_CTRL) bus_rdata[NUM_EN-1:0]  = ctrl_q;
      if (bus_addr == A_DATA) bus_rdata[NUM_PIN-1:0] = data_q;
    end
  end
endmodule

// File: rtl/sfo_gate.sv
module sfo_gate
  import sfo_pkg::*;
#(
  parameter bit IDLE_HIGH = 1'b1
) (
  input  logic dat,
  input  logic en,
  input  logic sig,
  output logic pin
);
  generate
    if (IDLE_HIGH) begin : g_high
      assign pin = gate_high(dat, en, sig);
    end else begin : g_low
      assign pin = gate_low(dat, en, sig);
    end
  endgenerate
endmodule

// File: rtl/sfo_outmux.sv
module sfo_outmux
  import sfo_pkg::*;
#(
  parameter int       ADDR_W    = 2,
  parameter int       DATA_W    = 8,
  parameter int       CTRL_ADDR = 0,
  parameter int       DATA_ADDR = 1,
  parameter pin_vec_t DATA_RST  = 5'b10111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              lcd_line_clk,
  input  logic              lcd_frame,
  input  logic              tmr_clk,
  input  logic              buzz_in,
  input  logic              opt_b_alt,
  input  logic              opt_e_inv,
  output logic              pin_lc,
  output logic              pin_shared,
  output logic              pin_tmr,
  output logic              pin_buz,
  output logic              pin_buz_n
);
  en_vec_t  ctrl_q;
  pin_vec_t data_q;
  logic     wr_ctrl;
  logic     wr_data;

  sfo_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
    .DATA_ADDR(DATA_ADDR), .DATA_RST(DATA_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ctrl_q(ctrl_q), .data_q(data_q), .wr_ctrl(wr_ctrl), .wr_data(wr_data)
  );

  // named internal events for the checker
  logic frame_gated;    // frame path after data gating
  logic tmr_inv_path;   // inverted timer or LOW idle
  logic shared_alt;     // shared pin value in alternate mode

  sfo_gate #(.IDLE_HIGH(1'b1)) u_lc (
    .dat(data_q[D_LC]), .en(ctrl_q[EN_LINE]), .sig(lcd_line_clk), .pin(pin_lc));

  sfo_gate #(.IDLE_HIGH(1'b1)) u_tmr (
    .dat(data_q[D_TMR]), .en(ctrl_q[EN_TMR]), .sig(tmr_clk), .pin(pin_tmr));

  sfo_gate #(.IDLE_HIGH(1'b0)) u_buz (
    .dat(data_q[D_BUZ]), .en(ctrl_q[EN_BUZ]), .sig(buzz_in), .pin(pin_buz));

  sfo_gate #(.IDLE_HIGH(1'b1)) u_frm (
    .dat(data_q[D_SHARED]), .en(ctrl_q[EN_FRAME]), .sig(lcd_frame), .pin(frame_gated));

  assign tmr_inv_path = ctrl_q[EN_TMR] ? ~tmr_clk : 1'b0;
  assign shared_alt   = ctrl_q[EN_FRAME] ? frame_gated : tmr_inv_path;
  assign pin_shared   = opt_b_alt ? shared_alt : data_q[D_SHARED];

  assign pin_buz_n    = opt_e_inv ? (ctrl_q[EN_BUZ] ? ~buzz_in : 1'b1) : data_q[D_BUZN];
endmodule

// File: rtl/sfo_outmux_chk.sv
module sfo_outmux_chk
  import sfo_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] bus_wdata,
  input en_vec_t           ctrl_q,
  input pin_vec_t          data_q,
  input logic              wr_ctrl,
  input logic              wr_data,
  input logic              lcd_frame,
  input logic              tmr_clk,
  input logic              buzz_in,
  input logic              opt_b_alt,
  input logic              opt_e_inv,
  input logic              pin_lc,
  input logic              pin_shared,
  input logic              pin_tmr,
  input logic              pin_buz,
  input logic              pin_buz_n
);
  p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> ctrl_q == $past(bus_wdata[NUM_EN-1:0]));

  p_data_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> data_q == $past(bus_wdata[NUM_PIN-1:0]));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ctrl || wr_data) |=> ($stable(ctrl_q) && $stable(data_q)));

  p_lc_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[EN_LINE] && data_q[D_LC]) |-> pin_lc);

  p_lc_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !data_q[D_LC] |-> !pin_lc);

  p_tmr_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[EN_TMR] && data_q[D_TMR]) |-> pin_tmr == tmr_clk);

  p_shared_tinv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (opt_b_alt && !ctrl_q[EN_FRAME] && ctrl_q[EN_TMR]) |-> pin_shared != tmr_clk);

  p_shared_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (opt_b_alt && ctrl_q[EN_FRAME] && data_q[D_SHARED]) |-> pin_shared == lcd_frame);

  p_shared_plain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !opt_b_alt |-> pin_shared == data_q[D_SHARED]);

  p_buz_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[EN_BUZ] |-> pin_buz == data_q[D_BUZ]);

  p_buzn_inv_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (opt_e_inv && ctrl_q[EN_BUZ]) |-> pin_buz_n != buzz_in);

  p_buzn_plain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !opt_e_inv |-> pin_buz_n == data_q[D_BUZN]);
endmodule

bind sfo_outmux sfo_outmux_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wdata(bus_wdata),
  .ctrl_q(ctrl_q), .data_q(data_q), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
  .lcd_frame(lcd_frame), .tmr_clk(tmr_clk), .buzz_in(buzz_in),
  .opt_b_alt(opt_b_alt), .opt_e_inv(opt_e_inv),
  .pin_lc(pin_lc), .pin_shared(pin_shared), .pin_tmr(pin_tmr),
  .pin_buz(pin_buz), .pin_buz_n(pin_buz_n)
);

// File: tb/sfo_outmux_test.sv
`timescale 1ns/1ps
module sfo_outmux_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       lcd_line_clk = 1'b0, lcd_frame = 1'b0, tmr_clk = 1'b0, buzz_in = 1'b0;
  logic       opt_b_alt = 1'b1, opt_e_inv = 1'b1;
  logic       pin_lc, pin_shared, pin_tmr, pin_buz, pin_buz_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  sfo_outmux uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lcd_line_clk(lcd_line_clk), .lcd_frame(lcd_frame), .tmr_clk(tmr_clk),
    .buzz_in(buzz_in), .opt_b_alt(opt_b_alt), .opt_e_inv(opt_e_inv),
    .pin_lc(pin_lc), .pin_shared(pin_shared), .pin_tmr(pin_tmr),
    .pin_buz(pin_buz), .pin_buz_n(pin_buz_n)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk);
    bus_sel = sel; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    bus_read(2'd0, v); check("R1 enable reset", v, 8'h00);
    bus_read(2'd1, v); check("R1 data reset", v, 8'h17);
    check("R1 pins reset", {3'b0, pin_buz_n, pin_buz, pin_tmr, pin_shared, pin_lc}, 8'b0001_0101);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    bus_write(2'd0, 8'hF5); bus_read(2'd0, v); check("R2 enable readback", v, 8'h05);
    bus_write(2'd1, 8'hAA); bus_read(2'd1, v); check("R2 data readback", v, 8'h0A);
    bus_write(2'd2, 8'hFF); bus_write(2'd3, 8'h00);
    bus_read(2'd0, v); check("R11 unused addr enable", v, 8'h05);
    bus_read(2'd1, v); check("R11 unused addr data", v, 8'h0A);
    bus_write(2'd0, 8'h00, 1'b0);
    bus_read(2'd0, v); check("R11 unselected write", v, 8'h05);
    bus_read(2'd2, v); check("R2 unused addr reads 0", v, 8'h00);
    bus_write(2'd0, 8'h00); bus_write(2'd1, 8'h17);
  endtask

  task automatic t_line();
    bus_write(2'd0, 8'h01);
    lcd_line_clk = 1'b1; settle(); check("R3 line clk high", pin_lc, 1);
    lcd_line_clk = 1'b0; settle(); check("R3 line clk low", pin_lc, 0);
    bus_write(2'd1, 8'h16); lcd_line_clk = 1'b1; settle();
    check("R3 data 0 suppresses", pin_lc, 0);
    bus_write(2'd1, 8'h17); bus_write(2'd0, 8'h00); lcd_line_clk = 1'b0; settle();
    check("R3 idle HIGH", pin_lc, 1);
  endtask

  task automatic t_timer();
    bus_write(2'd0, 8'h04);
    tmr_clk = 1'b1; settle(); check("R4 tmr high", pin_tmr, 1);
    check("R5 shared inverted", pin_shared, 0);
    tmr_clk = 1'b0; settle(); check("R4 tmr low", pin_tmr, 0);
    check("R5 shared inverted low", pin_shared, 1);
    bus_write(2'd1, 8'h15); settle();
    check("R5 data bit1 ignored", pin_shared, 1);
    bus_write(2'd1, 8'h13); settle(); check("R4 data 0 suppresses", pin_tmr, 0);
    bus_write(2'd1, 8'h17); bus_write(2'd0, 8'h00); settle();
    check("R5 shared LOW idle", pin_shared, 0);
    check("R4 tmr HIGH idle", pin_tmr, 1);
  endtask

  task automatic t_shared();
    bus_write(2'd0, 8'h06);
    tmr_clk = 1'b1; lcd_frame = 1'b1; settle(); check("R6 frame wins high", pin_shared, 1);
    lcd_frame = 1'b0; settle(); check("R6 frame wins low", pin_shared, 0);
    lcd_frame = 1'b1; bus_write(2'd1, 8'h15); settle();
    check("R6 data 0 suppresses frame", pin_shared, 0);
    bus_write(2'd0, 8'h04); settle(); check("R5 back to inverted tmr", pin_shared, 0);
    tmr_clk = 1'b0; settle(); check("R5 inverted tmr data0", pin_shared, 1);
    opt_b_alt = 1'b0; settle(); check("R7 option off data 0", pin_shared, 0);
    bus_write(2'd1, 8'h17); bus_write(2'd0, 8'h06); settle();
    check("R7 option off data 1", pin_shared, 1);
    opt_b_alt = 1'b1; bus_write(2'd0, 8'h00); lcd_frame = 1'b0; settle();
  endtask

  task automatic t_buzzer();
    bus_write(2'd0, 8'h08);
    buzz_in = 1'b1; settle(); check("R8 buz high", pin_buz, 1);
    check("R9 buz_n inverse", pin_buz_n, 0);
    buzz_in = 1'b0; settle(); check("R8 buz low", pin_buz, 0);
    check("R9 buz_n inverse high", pin_buz_n, 1);
    bus_write(2'd1, 8'h0F); buzz_in = 1'b1; settle();
    check("R8 data 1 masks tone", pin_buz, 1);
    check("R9 data bit4 ignored", pin_buz_n, 0);
    opt_e_inv = 1'b0; settle(); check("R10 option off data 0", pin_buz_n, 0);
    bus_write(2'd1, 8'h17); settle(); check("R10 option off data 1", pin_buz_n, 1);
    opt_e_inv = 1'b1; bus_write(2'd0, 8'h00); settle();
    check("R9 idle HIGH", pin_buz_n, 1);
    check("R8 idle LOW", pin_buz, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_line();
    t_timer();
    t_shared();
    t_buzzer();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule